// File: doc/BRIEF.md
# Dual-Range Dual-Modulus Prescaler

This block divides a fast input clock by one of two neighbouring ratios, N or N+1, for use ahead of the programmable counters of a frequency-synthesizer loop. The base ratio N is 16 or 32, picked by a static range input. A modulus input picks, once per output period, whether the next period gets the one extra input clock. The loop's swallow counter can therefore steer the ratio period by period.

The output is a registered signal clocked by the input clock. Its edges keep a fixed relation to the input clock whatever the decode depth of the count chain, so that delay never adds to the loop. The output is high for the first half of the base count. Any extra clock lengthens the low phase. Both control inputs are captured in a single input-clock cycle, the final one of each output period, and that capture governs the whole following period. Changes at any other time have no effect.

Top module: `dual_mod_prescaler`

## Requirements
- R1: With `range_hi`=0 and `mod_ctl`=1 captured, an output period is 16 input clocks: 8 high, then 8 low.
- R2: With `range_hi`=0 and `mod_ctl`=0 captured, an output period is 17 input clocks: 8 high, then 9 low.
- R3: With `range_hi`=1 and `mod_ctl`=1 captured, an output period is 32 input clocks: 16 high, then 16 low.
- R4: With `range_hi`=1 and `mod_ctl`=0 captured, an output period is 33 input clocks: 16 high, then 17 low.
- R5: `mod_ctl` is captured only at the input clock edge one cycle before the output's rising edge. The captured value sets the ratio of the period that begins at that rising edge. A value of `mod_ctl` held at any other edge has no effect on any period.
- R6: `range_hi` is captured at the same edge as `mod_ctl`. A change in mid-period leaves the current period at its old length and high time, and the next period has the new range.
- R7: While `rst` is high, `div_out` is low. `div_out` goes high at the first clock edge after `rst` is released, and that first period uses the higher ratio, N+1, for the range held during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| range_hi | input | 1 | Base ratio select: 0 gives 16, 1 gives 32 |
| mod_ctl | input | 1 | Ratio choice for the next period: 1 gives N, 0 gives N+1 |
| div_out | output | 1 | Divided clock, registered on `clk` |

## Verification
The sharpest corner case is the capture instant. The bench moves `mod_ctl` to a new value only during the single cycle before the capture edge, and also during every cycle except that one. A design sampling one cycle early or late, or sampling level-wise throughout the period, gives the wrong ratio in one of the two cases. A range change placed at the start of a period catches a design that applies the range at once: the current period would come out with the wrong high time or a truncated count. Reset is checked for a low output, a rising edge exactly one cycle after release and a first period of N+1. A design that defaults to N, or that lets the first period start late, is caught by these checks.

// File: rtl/psc_pkg.sv
package psc_pkg;

    // Ratio set that governs one output period.
    typedef struct packed {
        logic wide;   // 1: base ratio doubled
        logic extra;  // 1: one clock added to the low phase
    } psc_cfg_t;

    // Input clocks in the high phase of a period.
    function automatic int unsigned high_len(psc_cfg_t c, int unsigned base);
        return c.wide ? base : base / 2;
    endfunction

    // Total input clocks in a period.
    function automatic int unsigned period_len(psc_cfg_t c, int unsigned base);
        return (c.wide ? 2 * base : base) + (c.extra ? 1 : 0);
    endfunction

endpackage

// File: rtl/psc_ctrl.sv
module psc_ctrl
    import psc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wrap,
    input  logic     range_hi,
    input  logic     mod_ctl,
    output psc_cfg_t cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.wide  <= range_hi;
            cfg.extra <= 1'b1;
        end else if (wrap) begin
            cfg.wide  <= range_hi;
            cfg.extra <= ~mod_ctl;
        end
    end

    // R5: the ratio of the next period is taken from mod_ctl at the wrap edge
    p_sample_point_r5: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (cfg.extra == !$past(mod_ctl)));

    // R6: settings hold for the whole period
    p_cfg_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(cfg));

endmodule

// File: rtl/psc_counter.sv
module psc_counter
    import psc_pkg::*;
#(
    parameter int unsigned BASE_DIV = 16,
    parameter int unsigned CW       = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  psc_cfg_t      cfg,
    output logic [CW-1:0] cnt,
    output logic          wrap
);

    logic [CW-1:0] last_cnt;

    always_comb begin
        last_cnt = CW'(period_len(cfg, BASE_DIV) - 1);
        wrap     = (cnt == last_cnt);
    end

    always_ff @(posedge clk) begin
        if (rst || wrap) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end

    // R6: count never passes the end of the largest period
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(2 * BASE_DIV));

endmodule

// File: rtl/psc_retime.sv
module psc_retime
    import psc_pkg::*;
#(
    parameter int unsigned BASE_DIV = 16,
    parameter int unsigned CW       = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cnt,
    input  psc_cfg_t      cfg,
    output logic          div_out
);

    logic [CW-1:0] half_cnt;

    always_comb half_cnt = CW'(high_len(cfg, BASE_DIV));

    always_ff @(posedge clk) begin
        if (rst) div_out <= 1'b0;
        else     div_out <= (cnt < half_cnt);
    end

    // R1: output rises only on the first count of a period
    p_rise_at_start_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(div_out) |-> ($past(cnt) == '0));

    // R3: output falls only when the high phase is complete
    p_fall_at_half_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(div_out) |-> ($past(cnt) == $past(half_cnt)));

endmodule

// File: rtl/dual_mod_prescaler.sv
module dual_mod_prescaler
    import psc_pkg::*;
#(
    parameter int unsigned BASE_DIV = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic range_hi,
    input  logic mod_ctl,
    output logic div_out
);

    localparam int unsigned CW = $clog2(2 * BASE_DIV + 1);

    psc_cfg_t      cfg;
    logic [CW-1:0] cnt;
    logic          wrap;

    psc_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wrap     (wrap),
        .range_hi (range_hi),
        .mod_ctl  (mod_ctl),
        .cfg      (cfg)
    );

    psc_counter #(.BASE_DIV(BASE_DIV), .CW(CW)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .cfg  (cfg),
        .cnt  (cnt),
        .wrap (wrap)
    );

    psc_retime #(.BASE_DIV(BASE_DIV), .CW(CW)) u_out (
        .clk     (clk),
        .rst     (rst),
        .cnt     (cnt),
        .cfg     (cfg),
        .div_out (div_out)
    );

    // R7: reset holds the output low
    p_reset_low_r7: assert property (@(posedge clk)
        rst |=> !div_out);

endmodule

// File: tb/sim_dual_mod_prescaler.sv
module sim_dual_mod_prescaler;

    localparam int BASE = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic range_hi = 1'b0;
    logic mod_ctl = 1'b1;
    logic div_out;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    dual_mod_prescaler #(.BASE_DIV(BASE)) u0 (
        .clk(clk), .rst(rst), .range_hi(range_hi),
        .mod_ctl(mod_ctl), .div_out(div_out)
    );

    always #5 clk = ~clk;

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: act=%0d exp<=%0d cycles", cyc, 50000);
            summary();
            $finish;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_hi(bit wide);
        return wide ? BASE : BASE / 2;
    endfunction

    function automatic int exp_len(bit wide, bit m);
        return (wide ? 2 * BASE : BASE) + (m ? 0 : 1);
    endfunction

    // Leaves the bench at the first falling clock edge with the output newly high.
    task automatic wait_rise();
        @(negedge clk);
        while (div_out) @(negedge clk);
        while (!div_out) @(negedge clk);
    endtask

    // Starts at a rise negedge, ends at the next one.
    task automatic measure(output int hi, output int lo);
        hi = 0;
        lo = 0;
        while (div_out) begin hi++; @(negedge clk); end
        while (!div_out) begin lo++; @(negedge clk); end
    endtask

    task automatic t_reset();
        int h, l;
        rst = 1'b1;
        range_hi = 1'b0;
        mod_ctl = 1'b1;
        repeat (4) @(negedge clk);
        chk("R7", "output in reset", int'(div_out), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R7", "output one clock after release", int'(div_out), 1);
        measure(h, l);
        chk("R7", "first high time", h, 8);
        chk("R7", "first low time", l, 9);
        measure(h, l);
        chk("R1", "high after first period", h, 8);
        chk("R1", "low after first period", l, 8);
    endtask

    task automatic t_ratio(string req, bit wide, bit m);
        int h, l;
        range_hi = wide;
        mod_ctl = m;
        wait_rise();
        measure(h, l);
        measure(h, l);
        chk(req, "high time", h, exp_hi(wide));
        chk(req, "low time", l, exp_len(wide, m) - exp_hi(wide));
    endtask

    // Only the value in the capture cycle counts (R5).
    task automatic t_window(bit wide, bit win_val, bit out_val);
        int h, l;
        int len;
        range_hi = wide;
        mod_ctl = win_val;
        wait_rise();
        measure(h, l);
        len = exp_len(wide, win_val);
        mod_ctl = out_val;
        repeat (len - 2) @(negedge clk);
        mod_ctl = win_val;
        @(negedge clk);
        mod_ctl = out_val;
        @(negedge clk);
        measure(h, l);
        chk("R5", "period with window value", h + l, exp_len(wide, win_val));
        chk("R5", "high time with window value", h, exp_hi(wide));
    endtask

    task automatic t_range();
        int h, l;
        mod_ctl = 1'b1;
        range_hi = 1'b0;
        wait_rise();
        measure(h, l);
        range_hi = 1'b1;
        measure(h, l);
        chk("R6", "current period after raise, high", h, 8);
        chk("R6", "current period after raise, low", l, 8);
        measure(h, l);
        chk("R6", "next period after raise, high", h, 16);
        chk("R6", "next period after raise, low", l, 16);
        range_hi = 1'b0;
        measure(h, l);
        chk("R6", "current period after drop", h + l, 32);
        measure(h, l);
        chk("R6", "next period after drop", h + l, 16);
    endtask

    initial begin
        t_reset();
        t_ratio("R1", 1'b0, 1'b1);
        t_ratio("R2", 1'b0, 1'b0);
        t_ratio("R3", 1'b1, 1'b1);
        t_ratio("R4", 1'b1, 1'b0);
        t_ratio("R2", 1'b0, 1'b0);
        t_window(1'b0, 1'b1, 1'b0);
        t_window(1'b0, 1'b0, 1'b1);
        t_window(1'b1, 1'b1, 1'b0);
        t_window(1'b1, 1'b0, 1'b1);
        t_range();
        summary();
        $finish;
    end

endmodule